// File: doc/BRIEF.md
# Thirty-Two Source Interrupt Controller

This block gathers thirty-two interrupt inputs and turns them into two requests for a processor. One request is ordinary and the other is critical. Software sets up each source through a small register bus with a word address, write data, registered read data and separate read and write strobes. Each source is either level-sensitive or edge-triggered. Each source also has its own active sense: high or rising, or low or falling.

Captured events stay in a status register until software clears them by writing ones. An enable register gates which captured events reach the outputs. A critical register sends each enabled source to one of the two request lines. Software can read the masked view, status AND enable, at its own word. A request line from one instance can drive a source input of another, which builds a two-level tree.

Top module: `irq_ctrl`

## Requirements
- R1: Source n sits at bit (31 − n) of the input vector and of every register, so source 0 is the MSB. The word offsets are: status 0x0, enable 0x2, critical 0x3, sense 0x4, trigger 0x5, masked status 0x6.
- R2: Reset clears enable, critical, sense, trigger and both request outputs. Every source then behaves as a level-sensitive, active-low, disabled source, so with all inputs low the status register reads 0xFFFFFFFF shortly after reset.
- R3: A source with trigger bit 0 is level-sensitive. Its status bit sets while the input is at its active level, which is high when the sense bit is 1 and low when it is 0.
- R4: A source with trigger bit 1 is edge-triggered. Its status bit sets once, on a change into the active level: a rising edge when the sense bit is 1, a falling edge when it is 0. An input that stays at the active level sets nothing more.
- R5: A write to status clears each bit written as 1 and leaves each bit written as 0 unchanged. Writing 0xFFFFFFFF clears every pending edge event.
- R6: A level source still at its active level keeps its status bit set through a clear, whether or not it is enabled.
- R7: Status bits capture events whether the source is enabled or not.
- R8: The masked-status word reads status AND enable.
- R9: The ordinary request is the OR of masked-status bits whose critical bit is 0. The critical request is the OR of masked-status bits whose critical bit is 1. Both are registered, one cycle behind status.
- R10: Reads of any other offset, including 0x1, 0x7, 0x8 and 0x9 to 0xF, return zero. Writes to those offsets change nothing.
- R11: When one instance's ordinary request drives a level-sensitive, active-high source of a second instance, an enabled event at the first instance appears in the second instance's masked status and ordinary request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_in | input | 32 | Interrupt inputs, source n on bit 31−n, asynchronous |
| bus_addr | input | 4 | Register word offset |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 32 | Read data, valid the cycle after the read strobe, zero otherwise |
| irq_norm | output | 1 | Ordinary interrupt request |
| irq_crit | output | 1 | Critical interrupt request |

## Verification
Take an input that is stable before clock edge k. It reaches the second synchroniser stage at edge k+1, sets status at edge k+2 and moves a request output at edge k+3. A register write takes effect on the edge that samples its strobe. Read data appears after the edge that samples the read strobe and drops to zero one cycle later. A behavioural model in the bench runs the same timeline and is compared with both instances on every falling edge. The directed reads wait at least six cycles after a stimulus, so each one sees settled status no matter how deep the path is.

// File: rtl/irq_pkg.sv
// Shared constants for the interrupt controller: source count, bus
// address width and the word offsets that software decodes.
package irq_pkg;
    localparam int NSRC   = 32;
    localparam int ADDR_W = 4;

    typedef logic [ADDR_W-1:0] reg_addr_t;

    localparam reg_addr_t OFF_STAT = 4'h0;
    localparam reg_addr_t OFF_EN   = 4'h2;
    localparam reg_addr_t OFF_CRIT = 4'h3;
    localparam reg_addr_t OFF_POL  = 4'h4;
    localparam reg_addr_t OFF_TRIG = 4'h5;
    localparam reg_addr_t OFF_MASK = 4'h6;
endpackage

// File: rtl/irq_sense.sv
// Input conditioning for every source.
// What it does: it brings each raw input through a two-flop synchroniser and
// keeps the previous synchronised value. For each bit it raises a one-cycle
// or steady 'hit' that follows the bit's trigger and sense settings.
// Assumes: raw inputs are asynchronous. The sense and trigger vectors are
// synchronous register outputs.
module irq_sense #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw,
    input  logic [N-1:0] sense,
    input  logic [N-1:0] trig,
    output logic [N-1:0] hit
);
    logic [N-1:0] sync_a;
    logic [N-1:0] sync_b;
    logic [N-1:0] prev_b;

    // Purpose: synchronise inputs and remember last synchronised sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_a <= '0;
            sync_b <= '0;
            prev_b <= '0;
        end else begin
            sync_a <= raw;
            sync_b <= sync_a;
            prev_b <= sync_b;
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_src
        logic now_act;
        logic old_act;
        // Purpose: active-level test of the current and previous sample.
        assign now_act = (sync_b[i] == sense[i]);
        assign old_act = (prev_b[i] == sense[i]);
        // Purpose: edge mode wants an entry into the active level, level mode any active sample.
        assign hit[i]  = trig[i] ? (now_act && !old_act) : now_act;
    end
endmodule

// File: rtl/irq_regs.sv
// Register file and status store.
// What it does: it decodes bus writes into the enable, critical, sense and
// trigger registers. It keeps the status register, where a new hit takes
// priority over a write-one clear. It produces the masked status and
// registered read data.
// Assumes: single-cycle strobes, and wr and rd are never both high.
module irq_regs
    import irq_pkg::*;
#(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  reg_addr_t    addr,
    input  logic [N-1:0] wdata,
    input  logic         wr,
    input  logic         rd,
    input  logic [N-1:0] hit,
    output logic [N-1:0] rdata,
    output logic [N-1:0] masked,
    output logic [N-1:0] crit_q,
    output logic [N-1:0] sense_q,
    output logic [N-1:0] trig_q
);
    logic [N-1:0] stat_q;
    logic [N-1:0] en_q;
    logic [N-1:0] clr_mask;
    logic [N-1:0] rd_mux;
    logic         mapped;

    // Purpose: write-one-to-clear mask for the status word.
    assign clr_mask = (wr && addr == OFF_STAT) ? wdata : '0;
    // Purpose: enabled view of status.
    assign masked   = stat_q & en_q;

    // Purpose: mark the offsets that hold state or read back.
    always_comb begin
        case (addr)
            OFF_STAT, OFF_EN, OFF_CRIT, OFF_POL, OFF_TRIG, OFF_MASK: mapped = 1'b1;
            default: mapped = 1'b0;
        endcase
    end

    // Purpose: configuration registers written from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= '0;
            crit_q  <= '0;
            sense_q <= '0;
            trig_q  <= '0;
        end else if (wr) begin
            case (addr)
                OFF_EN:   en_q    <= wdata;
                OFF_CRIT: crit_q  <= wdata;
                OFF_POL:  sense_q <= wdata;
                OFF_TRIG: trig_q  <= wdata;
                default: ;
            endcase
        end
    end

    // Purpose: status capture; a hit in the same cycle overrides a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr_mask) | hit;
    end

    // Purpose: read multiplexer; unmapped and vector offsets give zero.
    always_comb begin
        case (addr)
            OFF_STAT: rd_mux = stat_q;
            OFF_EN:   rd_mux = en_q;
            OFF_CRIT: rd_mux = crit_q;
            OFF_POL:  rd_mux = sense_q;
            OFF_TRIG: rd_mux = trig_q;
            OFF_MASK: rd_mux = masked;
            default:  rd_mux = '0;
        endcase
    end

    // Purpose: registered read data, zero when no read is in progress.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else        rdata <= rd ? rd_mux : '0;
    end

    // R5: bits written as 1 with no concurrent hit are clear afterwards.
    a_r5_clear_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == OFF_STAT) |=> ((stat_q & $past(wdata) & ~$past(hit)) == '0));

    // R6: a hit always leaves its status bit set, clear or not.
    a_r6_hit_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit) |=> ((stat_q & $past(hit)) == $past(hit)));

    // R8: a masked-status read never shows a disabled source.
    a_r8_masked_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && addr == OFF_MASK) |=> ((rdata & ~$past(en_q)) == '0));

    // R10: writes to unmapped offsets leave configuration untouched.
    a_r10_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !mapped) |=> ($stable(en_q) && $stable(crit_q) && $stable(sense_q) && $stable(trig_q)));
endmodule

// File: rtl/irq_merge.sv
// Request generation.
// What it does: it reduces the masked status into the ordinary and critical
// request lines, splitting by the critical register, and registers both.
// Assumes: masked and crit are synchronous to clk.
module irq_merge #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] masked,
    input  logic [N-1:0] crit,
    output logic         irq_norm,
    output logic         irq_crit
);
    // Purpose: registered OR-reduction per request class.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_norm <= 1'b0;
            irq_crit <= 1'b0;
        end else begin
            irq_norm <= |(masked & ~crit);
            irq_crit <= |(masked & crit);
        end
    end

    // R9: no request one cycle after an empty masked status.
    a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (masked == '0) |=> (!irq_norm && !irq_crit));

    // R9: a critical request needs a critical masked source a cycle earlier.
    a_r9_crit_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq_crit |-> $past(|(masked & crit)));
endmodule

// File: rtl/irq_ctrl.sv
// Top level of the interrupt controller.
// What it does: it joins input conditioning, the register file and request
// generation. Source n is carried on bit (NSRC-1-n) everywhere.
// Assumes: one clock domain for the bus, and a synchronous active-low reset.
module irq_ctrl
    import irq_pkg::*;
#(
    parameter int NSRC_P = irq_pkg::NSRC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC_P-1:0] src_in,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NSRC_P-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [NSRC_P-1:0] bus_rdata,
    output logic              irq_norm,
    output logic              irq_crit
);
    logic [NSRC_P-1:0] hit;
    logic [NSRC_P-1:0] masked;
    logic [NSRC_P-1:0] crit_q;
    logic [NSRC_P-1:0] sense_q;
    logic [NSRC_P-1:0] trig_q;

    irq_sense #(.N(NSRC_P)) u_sense (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   (src_in),
        .sense (sense_q),
        .trig  (trig_q),
        .hit   (hit)
    );

    irq_regs #(.N(NSRC_P)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .wr      (bus_wr),
        .rd      (bus_rd),
        .hit     (hit),
        .rdata   (bus_rdata),
        .masked  (masked),
        .crit_q  (crit_q),
        .sense_q (sense_q),
        .trig_q  (trig_q)
    );

    irq_merge #(.N(NSRC_P)) u_merge (
        .clk      (clk),
        .rst_n    (rst_n),
        .masked   (masked),
        .crit     (crit_q),
        .irq_norm (irq_norm),
        .irq_crit (irq_crit)
    );
endmodule

// File: tb/test_irq_ctrl.sv
// Behavioural reference of one controller instance, cycle-accurate to the
// requirement timeline (two sync stages, status, registered outputs).
module ref_intc (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] src,
    input  logic [3:0]  addr,
    input  logic [31:0] wdata,
    input  logic        wr,
    input  logic        rd,
    output logic [31:0] rdata,
    output logic        irqn,
    output logic        irqc
);
    logic [31:0] d1, d2, dp, st, en, cr, pl, tg;

    always @(posedge clk) begin
        if (!rst_n) begin
            d1 <= 0; d2 <= 0; dp <= 0; st <= 0; en <= 0; cr <= 0;
            pl <= 0; tg <= 0; rdata <= 0; irqn <= 0; irqc <= 0;
        end else begin
            logic [31:0] act, was, ev, clr;
            act = ~(d2 ^ pl);
            was = ~(dp ^ pl);
            ev  = (act & ~tg) | (act & ~was & tg);
            clr = (wr && addr == 4'd0) ? wdata : 32'd0;
            irqn <= |(st & en & ~cr);
            irqc <= |(st & en & cr);
            st <= (st & ~clr) | ev;
            d1 <= src; d2 <= d1; dp <= d2;
            if (wr) begin
                if (addr == 4'd2) en <= wdata;
                if (addr == 4'd3) cr <= wdata;
                if (addr == 4'd4) pl <= wdata;
                if (addr == 4'd5) tg <= wdata;
            end
            if (!rd)              rdata <= 0;
            else if (addr == 4'd0) rdata <= st;
            else if (addr == 4'd2) rdata <= en;
            else if (addr == 4'd3) rdata <= cr;
            else if (addr == 4'd4) rdata <= pl;
            else if (addr == 4'd5) rdata <= tg;
            else if (addr == 4'd6) rdata <= st & en;
            else                   rdata <= 0;
        end
    end
endmodule

module test_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] p_src = 32'd0;
    logic [31:0] s_src = 32'd0;
    logic [3:0]  addr = 4'd0;
    logic [31:0] wdata = 32'd0;
    logic        wr_p = 1'b0, rd_p = 1'b0, wr_s = 1'b0, rd_s = 1'b0;
    logic        cmp_on = 1'b0;
    int          tests = 0;
    int          fails = 0;

    localparam logic [31:0] CASC_BIT = 32'h0400_0000; // source 5 of primary

    logic [31:0] p_rdata, s_rdata, mp_rdata, ms_rdata;
    logic        p_norm, p_crit, s_norm, s_crit;
    logic        mp_norm, mp_crit, ms_norm, ms_crit;
    logic [31:0] p_in, mp_in;

    always #2 clk = ~clk;   // 250 MHz

    assign p_in  = (p_src & ~CASC_BIT) | (s_norm  ? CASC_BIT : 32'd0);
    assign mp_in = (p_src & ~CASC_BIT) | (ms_norm ? CASC_BIT : 32'd0);

    irq_ctrl i_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .src_in(p_in), .bus_addr(addr),
        .bus_wdata(wdata), .bus_wr(wr_p), .bus_rd(rd_p),
        .bus_rdata(p_rdata), .irq_norm(p_norm), .irq_crit(p_crit));

    irq_ctrl i_irq_ctrl_sec (
        .clk(clk), .rst_n(rst_n), .src_in(s_src), .bus_addr(addr),
        .bus_wdata(wdata), .bus_wr(wr_s), .bus_rd(rd_s),
        .bus_rdata(s_rdata), .irq_norm(s_norm), .irq_crit(s_crit));

    ref_intc m_pri (.clk(clk), .rst_n(rst_n), .src(mp_in), .addr(addr),
        .wdata(wdata), .wr(wr_p), .rd(rd_p), .rdata(mp_rdata),
        .irqn(mp_norm), .irqc(mp_crit));

    ref_intc m_sec (.clk(clk), .rst_n(rst_n), .src(s_src), .addr(addr),
        .wdata(wdata), .wr(wr_s), .rd(rd_s), .rdata(ms_rdata),
        .irqn(ms_norm), .irqc(ms_crit));

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    // Per-cycle comparison of both instances against the model (R1, R9).
    always @(negedge clk) begin
        if (cmp_on) begin
            check("R1 primary read data", p_rdata, mp_rdata);
            check("R9 primary requests", {30'd0, p_norm, p_crit}, {30'd0, mp_norm, mp_crit});
            check("R1 secondary read data", s_rdata, ms_rdata);
            check("R9 secondary requests", {30'd0, s_norm, s_crit}, {30'd0, ms_norm, ms_crit});
        end
    end

    task automatic wait_cy(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_reg(input bit sec, input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d;
        if (sec) wr_s = 1'b1; else wr_p = 1'b1;
        @(negedge clk);
        wr_s = 1'b0; wr_p = 1'b0;
    endtask

    task automatic rd_chk(input bit sec, input logic [3:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        addr = a;
        if (sec) rd_s = 1'b1; else rd_p = 1'b1;
        @(negedge clk);
        check(req, sec ? s_rdata : p_rdata, exp);
        rd_s = 1'b0; rd_p = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete, got timeout expected completion");
        finish_run();
    end

    initial begin
        wait_cy(4);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        wait_cy(6);

        // R2: reset values; idle-low inputs look active under active-low default
        rd_chk(0, 4'h2, 32'h0, "R2 enable after reset");
        rd_chk(0, 4'h3, 32'h0, "R2 critical after reset");
        rd_chk(0, 4'h4, 32'h0, "R2 sense after reset");
        rd_chk(0, 4'h5, 32'h0, "R2 trigger after reset");
        rd_chk(0, 4'h0, 32'hFFFF_FFFF, "R2 status after reset");
        check("R2 requests after reset", {30'd0, p_norm, p_crit}, 32'd0);

        // R10: unmapped offsets
        rd_chk(0, 4'h1, 32'h0, "R10 read 0x1");
        rd_chk(0, 4'h7, 32'h0, "R10 read 0x7");
        rd_chk(0, 4'h8, 32'h0, "R10 read 0x8");
        rd_chk(0, 4'hF, 32'h0, "R10 read 0xF");
        wr_reg(0, 4'h1, 32'hFFFF_FFFF);
        wr_reg(0, 4'h7, 32'hFFFF_FFFF);
        wr_reg(0, 4'h8, 32'hFFFF_FFFF);
        wr_reg(0, 4'h9, 32'hFFFF_FFFF);
        rd_chk(0, 4'h2, 32'h0, "R10 enable untouched");
        rd_chk(0, 4'h4, 32'h0, "R10 sense untouched");
        rd_chk(0, 4'h7, 32'h0, "R10 vector still zero");

        // Init both: active-high, clear everything (R5)
        wr_reg(0, 4'h4, 32'hFFFF_FFFF);
        wr_reg(1, 4'h4, 32'hFFFF_FFFF);
        wait_cy(4);
        wr_reg(0, 4'h0, 32'hFFFF_FFFF);
        wr_reg(1, 4'h0, 32'hFFFF_FFFF);
        wait_cy(2);
        rd_chk(0, 4'h0, 32'h0, "R5 clear all primary");
        rd_chk(1, 4'h0, 32'h0, "R5 clear all secondary");

        // R3, R7: level source 3 (bit 28) active-high, disabled
        p_src[28] = 1'b1;
        wait_cy(6);
        rd_chk(0, 4'h0, 32'h1000_0000, "R3 R7 level latched while disabled");
        rd_chk(0, 4'h6, 32'h0, "R8 masked with enable zero");
        check("R9 no request while disabled", {31'd0, p_norm}, 32'd0);

        // R8, R9: enable source 3
        wr_reg(0, 4'h2, 32'h1000_0000);
        wait_cy(3);
        rd_chk(0, 4'h6, 32'h1000_0000, "R8 masked status");
        check("R9 ordinary request", {30'd0, p_norm, p_crit}, 32'd2);

        // R6: clear while still active, enabled and disabled
        wr_reg(0, 4'h0, 32'h1000_0000);
        rd_chk(0, 4'h0, 32'h1000_0000, "R6 level re-sets enabled");
        wr_reg(0, 4'h2, 32'h0);
        wr_reg(0, 4'h0, 32'h1000_0000);
        rd_chk(0, 4'h0, 32'h1000_0000, "R6 level re-sets disabled");
        wait_cy(3);
        check("R9 request drops on disable", {31'd0, p_norm}, 32'd0);
        p_src[28] = 1'b0;
        wait_cy(6);
        wr_reg(0, 4'h0, 32'h1000_0000);
        rd_chk(0, 4'h0, 32'h0, "R3 inactive level clears");

        // R4: source 0 rising edge, source 1 falling edge
        wr_reg(0, 4'h5, 32'hC000_0000);
        wr_reg(0, 4'h4, 32'hBFFF_FFFF);
        wait_cy(4);
        wr_reg(0, 4'h0, 32'hFFFF_FFFF);
        rd_chk(0, 4'h0, 32'h0, "R4 no event on configuration");
        p_src[31] = 1'b1;
        wait_cy(6);
        rd_chk(0, 4'h0, 32'h8000_0000, "R4 rising edge captured");
        wr_reg(0, 4'h0, 32'h8000_0000);
        wait_cy(4);
        rd_chk(0, 4'h0, 32'h0, "R4 held high sets nothing more");
        p_src[30] = 1'b1;
        wait_cy(6);
        rd_chk(0, 4'h0, 32'h0, "R4 rising ignored on falling source");
        p_src[30] = 1'b0;
        wait_cy(6);
        rd_chk(0, 4'h0, 32'h4000_0000, "R4 falling edge captured");

        // R5: partial clear
        p_src[31] = 1'b0;
        wait_cy(6);
        p_src[31] = 1'b1;
        wait_cy(6);
        rd_chk(0, 4'h0, 32'hC000_0000, "R5 two edges pending");
        wr_reg(0, 4'h0, 32'h4000_0000);
        rd_chk(0, 4'h0, 32'h8000_0000, "R5 zero bits unchanged");
        wr_reg(0, 4'h0, 32'hFFFF_FFFF);
        rd_chk(0, 4'h0, 32'h0, "R5 all ones clears edges");

        // R9: critical routing
        wr_reg(0, 4'h3, 32'h8000_0000);
        wr_reg(0, 4'h2, 32'hC000_0000);
        p_src[31] = 1'b0;
        wait_cy(6);
        p_src[31] = 1'b1;
        wait_cy(6);
        check("R9 critical only", {30'd0, p_norm, p_crit}, 32'd1);
        p_src[30] = 1'b1;
        wait_cy(6);
        p_src[30] = 1'b0;
        wait_cy(6);
        check("R9 both requests", {30'd0, p_norm, p_crit}, 32'd3);
        wr_reg(0, 4'h0, 32'hFFFF_FFFF);
        wait_cy(3);
        check("R9 both cleared", {30'd0, p_norm, p_crit}, 32'd0);

        // R11: cascade secondary source 10 -> primary source 5
        wr_reg(0, 4'h2, CASC_BIT);
        wr_reg(1, 4'h2, 32'h0020_0000);
        s_src[21] = 1'b1;
        wait_cy(12);
        check("R11 secondary request", {31'd0, s_norm}, 32'd1);
        rd_chk(0, 4'h6, CASC_BIT, "R11 primary masked shows cascade");
        check("R11 primary request", {30'd0, p_norm, p_crit}, 32'd2);
        s_src[21] = 1'b0;
        wait_cy(6);
        wr_reg(1, 4'h0, 32'h0020_0000);
        wait_cy(8);
        wr_reg(0, 4'h0, CASC_BIT);
        wait_cy(4);
        rd_chk(0, 4'h6, 32'h0, "R11 cascade cleared");
        check("R11 primary request dropped", {31'd0, p_norm}, 32'd0);

        wait_cy(2);
        finish_run();
    end
endmodule